// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked request interface and a 128K x 8 asynchronous static RAM. Each accepted request becomes one complete strobe sequence on the memory pins. A read holds chip enable and output enable low until the access time has passed, then registers the returned byte. A write drops chip enable and write enable together, drives the data bus for the required setup window, and keeps driving it for one hold cycle after the write ends. Between requests the memory is deselected and the bus is left floating.

All strobe lengths are whole clock counts. They are computed at elaboration from the clock period in picoseconds and from the memory's speed grade (10, 12, 15 or 20 ns), always rounding up. A parameter selects whether output enable stays high or stays low during writes. The write-pulse minimum and the point at which the controller starts driving both follow from that choice. After every read, a turnaround gap keeps the controller's drivers off until the memory's outputs have certainly released the bus.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `rvalid` is 0, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, and `mem_dq_drv` is 0.
- R2: Whenever `ready` is 1 the memory is deselected (`mem_ce_n` = 1) and the controller's data drivers are off.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for N_RD cycles, where N_RD * period covers both the grade's address/enable access time (equal to the read cycle time) and its output-enable access time. The byte on `mem_dq` is registered at the edge that ends this window.
- R4: `rvalid` is a single-cycle pulse issued together with the return of `ready`. It comes N_RD + N_TA edges after the accepting edge, where N_TA is the turnaround count of R8. `rdata` holds the byte read. Writes never raise `rvalid`.
- R5: With output enable held high during writes (`OE_LOW_WRITE` = 0), a write keeps `mem_oe_n` high and lowers `mem_we_n` only while `mem_ce_n` is low. The low time covers the high-OE pulse minimum, chip-enable-to-end, address-setup-to-end and data setup. `ready` returns N_WP + N_HOLD edges after acceptance.
- R6: With `OE_LOW_WRITE` = 1, the write pulse covers the longer low-OE minimum. The controller starts driving only once the memory's post-write-enable high-Z time has passed, and still meets data setup before the pulse ends.
- R7: The address stays constant for as long as chip enable is low. The controller's data remains driven in the cycle after write enable rises (hold).
- R8: After a read, the controller does not drive `mem_dq` until at least the output-enable/chip-enable high-Z time has elapsed. The gap is never shorter than one idle cycle.
- R9: Between two address changes that bracket a write, at least the grade's write cycle time passes.
- R10: The controller never drives `mem_dq` while the memory pins encode a read (chip enable low, output enable low, write enable high).
- R11: Each timing minimum is converted to cycles by ceiling division by `CLK_PS`, so every nonzero minimum yields at least one cycle.
- R12: A request is taken on a clock edge where `req` and `ready` are both 1. `wr` = 1 selects a write of `wdata` to `addr`; `wr` = 0 selects a read of `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address of the request |
| wdata | input | DW | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| rvalid | output | 1 | One-cycle pulse: rdata holds the byte read |
| rdata | output | DW | Registered read byte |
| mem_a | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | DW | Bidirectional memory data bus |
| mem_dq_drv | output | 1 | High while the controller drives mem_dq |

## Verification
The assertions watch the pin-level invariants on every cycle: no controller drive during a read encoding, write enable only inside chip enable, the write-time output-enable level, address stability, pulse and read-window lengths in picoseconds, the turnaround gap before drive, hold after the write ends, and the shape of the valid pulse. What they cannot show is whether the right byte reaches the right location. Only the bench's scenarios can show that, through full write and read-back sweeps and read-to-write and write-to-read pairs. These run against a behavioural memory that returns unknown data before the access time and checks setup, pulse, cycle and contention rules. The sweeps run for both write-OE variants.

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl #(
  parameter int CLK_PS       = 20000,
  parameter int GRADE_NS     = 12,
  parameter int OE_LOW_WRITE = 0,
  parameter int AW           = 17,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_a,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq,
  output logic          mem_dq_drv
);

  // kind: 0 access/cycle, 1 oe access / high-Z / data setup, 2 ce-to-end / short pulse, 3 addr-to-end, 4 long pulse
  function automatic int spec_ns(int g, int kind);
    int gi;
    gi = (g <= 10) ? 0 : (g <= 12) ? 1 : (g <= 15) ? 2 : 3;
    case (kind)
      0:       return (gi == 0) ? 10 : (gi == 1) ? 12 : (gi == 2) ? 15 : 20;
      1:       return 5 + gi;
      2:       return 7 + gi;
      3:       return (gi == 3) ? 12 : 8 + gi;
      default: return (gi == 0) ? 10 : (gi == 3) ? 15 : 12;
    endcase
  endfunction

  function automatic int cyc(int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_ACC_PS = spec_ns(GRADE_NS, 0) * 1000;
  localparam int T_OE_PS  = spec_ns(GRADE_NS, 1) * 1000;
  localparam int T_CEW_PS = spec_ns(GRADE_NS, 2) * 1000;
  localparam int T_AW_PS  = spec_ns(GRADE_NS, 3) * 1000;
  localparam int T_PW2_PS = spec_ns(GRADE_NS, 4) * 1000;

  localparam int N_RD    = mx(cyc(T_ACC_PS), cyc(T_OE_PS));
  localparam int N_TA    = mx(1, cyc(T_OE_PS));
  localparam int DRV_DLY = OE_LOW_WRITE ? cyc(T_OE_PS) : 0;
  localparam int N_WBASE = mx(cyc(T_CEW_PS), cyc(T_AW_PS));
  localparam int N_WP    = OE_LOW_WRITE ? mx(N_WBASE, mx(cyc(T_PW2_PS), DRV_DLY + cyc(T_OE_PS)))
                                        : mx(N_WBASE, cyc(T_OE_PS));
  localparam int N_HOLD  = mx(1, cyc(T_ACC_PS) - N_WP - 1);
  localparam int CW      = $clog2(mx(mx(N_RD, N_TA), mx(N_WP, N_HOLD)) + 1);

  localparam int T_RD_PS = mx(T_ACC_PS, T_OE_PS);
  localparam int T_WP_PS = OE_LOW_WRITE ? T_PW2_PS : T_CEW_PS;
  localparam int T_HZ_PS = T_OE_PS;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WHOLD} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] rd_q;
  logic          rv_q;
  logic          wr_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      a_q  <= '0;
      d_q  <= '0;
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req) begin
          a_q <= addr;
          d_q <= wdata;
          cnt <= '0;
          st  <= wr ? S_WR : S_RD;
        end
        S_RD: if (cnt == CW'(N_RD - 1)) begin
          rd_q <= mem_dq;
          cnt  <= '0;
          st   <= S_TURN;
        end else cnt <= cnt + 1'b1;
        S_TURN: if (cnt == CW'(N_TA - 1)) begin
          rv_q <= 1'b1;
          st   <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WR: if (cnt == CW'(N_WP - 1)) begin
          cnt <= '0;
          st  <= S_WHOLD;
        end else cnt <= cnt + 1'b1;
        S_WHOLD: if (cnt == CW'(N_HOLD - 1)) st <= S_IDLE;
                 else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (OE_LOW_WRITE != 0) begin : g_late_drive
      assign wr_drv = (cnt >= CW'(DRV_DLY));
    end else begin : g_early_drive
      assign wr_drv = 1'b1;
    end
  endgenerate

  assign ready      = (st == S_IDLE);
  assign rvalid     = rv_q;
  assign rdata      = rd_q;
  assign mem_a      = a_q;
  assign mem_ce_n   = !(st == S_RD || st == S_WR);
  assign mem_oe_n   = !(st == S_RD || (OE_LOW_WRITE != 0 && st == S_WR));
  assign mem_we_n   = !(st == S_WR);
  assign mem_dq_drv = (st == S_WR && wr_drv) || st == S_WHOLD;
  assign mem_dq     = mem_dq_drv ? d_q : {DW{1'bz}};

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int CLK_PS       = 20000,
  parameter int T_RD_PS      = 12000,
  parameter int T_WP_PS      = 8000,
  parameter int T_HZ_PS      = 6000,
  parameter int OE_LOW_WRITE = 0,
  parameter int AW           = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic [AW-1:0] mem_a,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_drv
);

  logic [7:0] lo_cnt, we_cnt, since_rd;
  logic       was_rd;
  logic       rd_pins;

  assign rd_pins = !mem_ce_n && !mem_oe_n && mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      we_cnt   <= '0;
      since_rd <= 8'hFF;
      was_rd   <= 1'b0;
    end else begin
      lo_cnt   <= mem_ce_n ? 8'd0 : (lo_cnt == 8'hFF ? lo_cnt : lo_cnt + 8'd1);
      we_cnt   <= mem_we_n ? 8'd0 : (we_cnt == 8'hFF ? we_cnt : we_cnt + 8'd1);
      since_rd <= rd_pins ? 8'd0 : (since_rd == 8'hFF ? since_rd : since_rd + 8'd1);
      was_rd   <= mem_ce_n ? 1'b0 : (rd_pins ? 1'b1 : was_rd);
    end
  end

  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_drv && rd_pins)); // R10
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_a)); // R7
  AST_READ_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && was_rd) |-> (int'(lo_cnt) * CLK_PS >= T_RD_PS)); // R11
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_cnt) * CLK_PS >= T_WP_PS)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_drv); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_drv) |-> (int'(since_rd) * CLK_PS >= T_HZ_PS)); // R8
  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R4
  AST_RVALID_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ready); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && !mem_dq_drv)); // R2

  generate
    if (OE_LOW_WRITE == 0) begin : g_oe_high_chk
      AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R5
    end
  endgenerate

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .CLK_PS(CLK_PS), .T_RD_PS(T_RD_PS), .T_WP_PS(T_WP_PS), .T_HZ_PS(T_HZ_PS),
  .OE_LOW_WRITE(OE_LOW_WRITE), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid), .mem_a(mem_a),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_drv(mem_dq_drv)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
// Behavioural 128K x 8 memory; it stores only 1024 words and expects a fixed high address field.
// Timing is measured in bench clocks times T_PS, the period the controller was told it runs at.
module sram_bhv #(
  parameter int T_PS = 2500,
  parameter logic [6:0] HI = 7'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [16:0] a,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        drv,
  inout  wire  [7:0]  dq
);
  // 12 ns grade minima (ps)
  localparam int T_ACC = 12000, T_OE = 6000, T_CEW = 8000, T_AW = 9000, T_PW2 = 12000;

  logic [7:0] mem [1024];
  logic       men = 1'b0;
  logic [7:0] mout = '0;
  assign dq = men ? mout : 8'hzz;

  int checks = 0, fails = 0;
  int k = 0, a_chg = 0, ce_fall = 0, oe_fall = 0, rd_end = -1000, ws = 0, d_chg = 0;
  bit p_rd = 0, p_wr = 0, p_drv = 0, pce = 1, poe = 1, oe_hi_w = 1, wr_in_cyc = 0;
  logic [16:0] pa = '0;
  logic [7:0]  pd = '0;

  initial for (int i = 0; i < 1024; i++) mem[i] = '0;

  task automatic flag(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s memory model %s: actual %0d expected >= %0d", tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    bit rd, wa;
    k++;
    rd = !ce_n && !oe_n && we_n;
    wa = !ce_n && !we_n;
    if (!rst_n) begin
      men = 1'b0;
      a_chg = k;
    end else begin
      if (p_wr && !wa) begin
        checks++;
        if ((k - ws) * T_PS < (oe_hi_w ? T_CEW : T_PW2))
          flag(oe_hi_w ? "R5" : "R6", "write pulse ps", (k - ws) * T_PS, oe_hi_w ? T_CEW : T_PW2);
        if ((k - ce_fall) * T_PS < T_CEW) flag("R5", "ce to write end ps", (k - ce_fall) * T_PS, T_CEW);
        if ((k - a_chg) * T_PS < T_AW) flag("R5", "address to write end ps", (k - a_chg) * T_PS, T_AW);
        if (!p_drv || (k - d_chg) * T_PS < T_OE) flag("R6", "data setup ps", (k - d_chg) * T_PS, T_OE);
        if (!drv) flag("R7", "data hold cycles", 0, 1);
        if (pa[16:10] != HI) flag("R7", "address high field", int'(pa[16:10]), int'(HI));
        mem[pa[9:0]] = pd;
      end
      if (p_rd && !rd) begin
        checks++;
        if ((k - ((a_chg > ce_fall) ? a_chg : ce_fall)) * T_PS < T_ACC)
          flag("R3", "read cycle ps", (k - ((a_chg > ce_fall) ? a_chg : ce_fall)) * T_PS, T_ACC);
        rd_end = k;
      end
      if (a !== pa) begin
        if (p_wr && wa) flag("R7", "address moved inside write", 1, 0);
        if (wr_in_cyc) begin
          checks++;
          if ((k - a_chg) * T_PS < T_ACC) flag("R9", "write cycle ps", (k - a_chg) * T_PS, T_ACC);
        end
        a_chg = k;
        wr_in_cyc = 0;
      end
      if (!ce_n && pce) ce_fall = k;
      if (!oe_n && poe) oe_fall = k;
      if (drv && (!p_drv || dq !== pd)) d_chg = k;
      if (wa && !p_wr) begin
        ws = k;
        oe_hi_w = oe_n;
        wr_in_cyc = 1;
      end
      if (wa && !oe_n) oe_hi_w = 0;
      if (drv) begin
        checks++;
        if (rd || (k - rd_end) * T_PS < T_OE)
          flag(rd ? "R10" : "R8", "bus contention gap ps", (k - rd_end) * T_PS, T_OE);
      end
      men = rd;
      if (rd && ((k + 1 - a_chg) * T_PS >= T_ACC) && ((k + 1 - ce_fall) * T_PS >= T_ACC) &&
          ((k + 1 - oe_fall) * T_PS >= T_OE) && a[16:10] == HI)
        mout = mem[a[9:0]];
      else
        mout = 8'hxx;
    end
    pa = a; pce = ce_n; poe = oe_n; p_rd = rd; p_wr = wa; p_drv = drv; pd = dq;
  end
endmodule

module sram_strobe_ctrl_test;
  localparam int TP = 2500;
  localparam logic [6:0] HI = 7'h55;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  req = '0;
  logic        wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  wire  [1:0]  rdy, rvld, ce, oe, we, dv;
  wire  [7:0]  rdat0, rdat1, dq0, dq1;
  wire  [16:0] ma0, ma1;

  sram_strobe_ctrl #(.CLK_PS(TP), .GRADE_NS(12), .OE_LOW_WRITE(0)) uut (
    .clk(clk), .rst_n(rst_n), .req(req[0]), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(rdy[0]), .rvalid(rvld[0]), .rdata(rdat0), .mem_a(ma0), .mem_ce_n(ce[0]),
    .mem_oe_n(oe[0]), .mem_we_n(we[0]), .mem_dq(dq0), .mem_dq_drv(dv[0]));
  sram_strobe_ctrl #(.CLK_PS(TP), .GRADE_NS(12), .OE_LOW_WRITE(1)) uut_oel (
    .clk(clk), .rst_n(rst_n), .req(req[1]), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(rdy[1]), .rvalid(rvld[1]), .rdata(rdat1), .mem_a(ma1), .mem_ce_n(ce[1]),
    .mem_oe_n(oe[1]), .mem_we_n(we[1]), .mem_dq(dq1), .mem_dq_drv(dv[1]));

  sram_bhv #(.T_PS(TP), .HI(HI)) m0 (.clk(clk), .rst_n(rst_n), .a(ma0), .ce_n(ce[0]),
    .oe_n(oe[0]), .we_n(we[0]), .drv(dv[0]), .dq(dq0));
  sram_bhv #(.T_PS(TP), .HI(HI)) m1 (.clk(clk), .rst_n(rst_n), .a(ma1), .ce_n(ce[1]),
    .oe_n(oe[1]), .we_n(we[1]), .drv(dv[1]), .dq(dq1));

  int vecs = 0, bad = 0;

  function automatic int cdiv(int ps); return (ps + TP - 1) / TP; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  // R3/R4/R8: read window covers 12 ns and 6 ns; turnaround covers 6 ns, at least 1
  localparam int RD_LAT = imax(cdiv(12000), cdiv(6000)) + imax(1, cdiv(6000));

  function automatic int wr_lat(int oel);
    int nwp;
    nwp = imax(cdiv(8000), cdiv(9000));
    nwp = oel ? imax(nwp, imax(cdiv(12000), cdiv(6000) + cdiv(6000))) : imax(nwp, cdiv(6000));
    return nwp + imax(1, cdiv(12000) - nwp - 1);
  endfunction

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 29 + s * 83 + 7) ^ (i >> 3));
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==",
             vecs + m0.checks + m1.checks, bad + m0.fails + m1.fails);
  endtask

  task automatic op(input int s, input bit w, input int idx, input logic [7:0] d,
                    output logic [7:0] q, output int lat);
    bit stray;
    stray = 0;
    while (!rdy[s]) @(negedge clk);
    req[s] = 1'b1; wr = w; addr = {HI, 10'(idx)}; wdata = d;
    @(negedge clk);
    req[s] = 1'b0;
    lat = 0;
    if (w) begin
      while (!rdy[s]) begin
        if (rvld[s]) stray = 1;
        @(negedge clk);
        lat++;
      end
      check(!stray && !rvld[s], "R4", "rvalid during write", int'(stray), 0);
    end else
      while (!rvld[s]) begin
        @(negedge clk);
        lat++;
      end
    q = (s == 0) ? rdat0 : rdat1;
  endtask

  task automatic sweep(input int s);
    logic [7:0] q;
    int lat;
    string wtag;
    wtag = (s == 0) ? "R5" : "R6";
    for (int i = 0; i < 1024; i++) begin
      op(s, 1'b1, i, pat(i, s), q, lat);
      check(lat == wr_lat(s), wtag, "write ready latency", lat, wr_lat(s));
    end
    for (int i = 0; i < 1024; i++) begin
      op(s, 1'b0, i, 8'h00, q, lat);
      check(q === pat(i, s), "R3", "read data", int'(q), int'(pat(i, s)));
      check(lat == RD_LAT, "R4", "read valid latency", lat, RD_LAT);
    end
    for (int i = 0; i < 256; i++) begin
      // write then immediate read (R12, R9)
      op(s, 1'b1, i * 4 + 1, ~pat(i * 4 + 1, s), q, lat);
      op(s, 1'b0, i * 4 + 1, 8'h00, q, lat);
      check(q === ~pat(i * 4 + 1, s), "R12", "write-then-read data", int'(q), int'(~pat(i * 4 + 1, s)));
      // read then immediate write across the turnaround (R8)
      op(s, 1'b0, i * 4 + 2, 8'h00, q, lat);
      check(q === pat(i * 4 + 2, s), "R8", "read before turnaround", int'(q), int'(pat(i * 4 + 2, s)));
      op(s, 1'b1, i * 4 + 2, 8'(i ^ 8'hA5), q, lat);
      op(s, 1'b0, i * 4 + 2, 8'h00, q, lat);
      check(q === 8'(i ^ 8'hA5), "R8", "write after turnaround", int'(q), int'(8'(i ^ 8'hA5)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdy == 2'b11 && rvld == 2'b00, "R1", "ready/rvalid after reset", int'({rdy, rvld}), 12);
    check(ce == 2'b11 && oe == 2'b11 && we == 2'b11 && dv == 2'b00, "R1", "pins in reset",
          int'({ce, oe, we, dv}), 8'hFC);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy == 2'b11 && ce == 2'b11 && dv == 2'b00, "R2", "idle deselect",
          int'({rdy, ce, dv}), 6'h3C);
    sweep(0);
    sweep(1);
    check(rdy == 2'b11 && ce == 2'b11 && dv == 2'b00, "R2", "idle after sweeps",
          int'({rdy, ce, dv}), 6'h3C);
    summary();
    $finish;
  end
endmodule